// File: doc/BRIEF.md
# Floating-Point Store Address and Data Unit

This block is the execute stage for the floating-point store operations of a 64-bit core. Each cycle it may accept one decoded store: a precision selector, an addressing form (base plus signed 16-bit displacement, or base plus index register), an update flag, the base register field and value, the index register value, the floating-point source value and the displacement. One clock later it presents a memory write request with the effective address, the byte count and right-justified store data. For update forms it also presents a write-back of the effective address to the base register.

Three data formats exist. A single-precision store narrows the 64-bit double-format source to a 32-bit single-format word without rounding. A double-precision store passes all 64 bits through. An integer-word store passes the low 32 bits through unchanged. The integer-word store is defined only as an indexed, non-update operation, so the unit forces that form for it.

The unit alters no status state. Decode, the register file, caches, alignment handling and the memory system sit around it.

Top module: `fst_store_unit`

## Requirements
- R1: With idx_form_i=0 the effective address is the base plus disp_i sign-extended to 64 bits, modulo 2^64.
- R2: With idx_form_i=1 the effective address is the base plus rb_val_i, modulo 2^64.
- R3: For a non-update operation with ra_sel_i=0 the base is zero, whatever ra_val_i holds.
- R4: For an update operation the base is ra_val_i, including when ra_sel_i=0.
- R5: An update operation with ra_sel_i nonzero drives wb_vld_o=1, wb_sel_o=ra_sel_i and wb_data_o equal to the effective address. A non-update operation drives wb_vld_o=0.
- R6: prec_i=1 (double) gives req_bytes_o=8 and req_data_o equal to frs_i. The encoding 3 behaves as double.
- R7: prec_i=0 (single) gives req_bytes_o=4 and req_data_o[63:32]=0. For a source exponent field (frs_i[62:52]) above 896, req_data_o[31:30]=frs_i[63:62] and req_data_o[29:0]=frs_i[58:29].
- R8: For a single store with source exponent field E from 874 to 896, the result is the sign bit, eight zero bits, then bits [51:29] of {1,frs_i[51:0]} shifted right by 897-E.
- R9: For a single store with source exponent field below 874, including zero, the bit mapping of R7 applies. No rounding is done in any range.
- R10: prec_i=2 (integer word) gives req_bytes_o=4 and req_data_o={32'b0, frs_i[31:0]}. It always uses the indexed form without update, so idx_form_i and upd_i have no effect and wb_vld_o stays 0.
- R11: An update operation with ra_sel_i=0 sets bad_form_o=1 and suppresses the write-back, while the store request is still issued at the R4 address.
- R12: Outputs appear exactly one clock after vld_i is sampled high. A cycle with vld_i low yields req_vld_o=0, wb_vld_o=0 and bad_form_o=0 on the next cycle.
- R13: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Decoded store present |
| prec_i | input | 2 | 0 single, 1 double, 2 integer word, 3 as double |
| idx_form_i | input | 1 | 1 indexed, 0 displacement |
| upd_i | input | 1 | Update form |
| ra_sel_i | input | 5 | Base register field |
| ra_val_i | input | 64 | Base register value |
| rb_val_i | input | 64 | Index register value |
| frs_i | input | 64 | Floating-point source value |
| disp_i | input | 16 | Signed displacement |
| req_vld_o | output | 1 | Write request valid |
| req_addr_o | output | 64 | Effective address |
| req_bytes_o | output | 4 | Bytes to write (4 or 8) |
| req_data_o | output | 64 | Right-justified store data |
| wb_vld_o | output | 1 | Base register write-back valid |
| wb_sel_o | output | 5 | Write-back register field |
| wb_data_o | output | 64 | Write-back value |
| bad_form_o | output | 1 | Update form named register 0 |

## Verification
Displacements are applied with both signs, and indexed offsets are applied as well. This separates sign extension from zero extension, and separates the displacement path from the index path. A nonzero ra_val_i is paired with ra_sel_i=0 in both update and non-update forms, so a missing or misapplied zero-base rule shows up in the address. Single conversion is driven at the exponent fields 873, 874, 893, 896 and 897, with signed zero, infinity and a value whose dropped bits are all ones. These cases catch off-by-one range limits, wrong shift counts and any rounding. The integer-word store is issued with the form and update inputs set the wrong way, to show that they are overridden.

// File: rtl/fst_pkg.sv
package fst_pkg;
  typedef enum logic [1:0] {
    PREC_SGL  = 2'd0,
    PREC_DBL  = 2'd1,
    PREC_WORD = 2'd2,
    PREC_RSV  = 2'd3
  } prec_e;

  localparam int DBL_W       = 64;
  localparam int SGL_W       = 32;
  localparam int DBL_EXP_W   = 11;
  localparam int DBL_FRAC_W  = 52;
  localparam int SGL_FRAC_W  = 23;
  // biased double exponents bounding the single denormal range
  localparam int SGL_NORM_MIN_BEXP = 897;
  localparam int SGL_DEN_MIN_BEXP  = 874;
endpackage

// File: rtl/fst_ea_gen.sv
module fst_ea_gen #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              idx_form_i,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  ra_sel_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [XLEN-1:0]   ea_o
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  always_comb begin
    base = (!upd_i && ra_sel_i == '0) ? '0 : ra_val_i;
    offs = idx_form_i ? rb_val_i : {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    ea_o = base + offs;
  end
endmodule

// File: rtl/fst_sp_pack.sv
module fst_sp_pack
  import fst_pkg::*;
(
  input  logic [DBL_W-1:29]  dbl_hi_i,
  output logic [SGL_W-1:0]   sgl_o
);
  localparam int SH_W = $clog2(SGL_FRAC_W + 1);

  logic [DBL_EXP_W-1:0]  bexp;
  logic                  den_rng;
  logic [SH_W-1:0]       shamt;
  logic [SGL_FRAC_W-1:0] den_frac;

  always_comb begin
    bexp    = dbl_hi_i[DBL_W-2 -: DBL_EXP_W];
    den_rng = (bexp >= DBL_EXP_W'(SGL_DEN_MIN_BEXP)) &&
              (bexp <  DBL_EXP_W'(SGL_NORM_MIN_BEXP));
    shamt   = SH_W'(DBL_EXP_W'(SGL_NORM_MIN_BEXP) - bexp);
    // implicit one restored, low fraction bits fall off (truncation)
    den_frac = SGL_FRAC_W'({1'b1, dbl_hi_i[DBL_FRAC_W-1:29]} >> shamt);
    if (den_rng)
      sgl_o = {dbl_hi_i[DBL_W-1], 8'h00, den_frac};
    else
      sgl_o = {dbl_hi_i[DBL_W-1 -: 2], dbl_hi_i[DBL_W-6:29]};
  end
endmodule

// File: rtl/fst_data_fmt.sv
module fst_data_fmt
  import fst_pkg::*;
#(
  parameter int BYTES_W = 4
) (
  input  logic [1:0]         prec_i,
  input  logic [DBL_W-1:0]   frs_i,
  output logic [DBL_W-1:0]   data_o,
  output logic [BYTES_W-1:0] bytes_o
);
  logic [SGL_W-1:0] sgl;

  fst_sp_pack u_sp_pack (
    .dbl_hi_i (frs_i[DBL_W-1:29]),
    .sgl_o    (sgl)
  );

  always_comb begin
    unique case (prec_e'(prec_i))
      PREC_SGL: begin
        data_o  = {{(DBL_W-SGL_W){1'b0}}, sgl};
        bytes_o = BYTES_W'(SGL_W / 8);
      end
      PREC_WORD: begin
        data_o  = {{(DBL_W-SGL_W){1'b0}}, frs_i[SGL_W-1:0]};
        bytes_o = BYTES_W'(SGL_W / 8);
      end
      default: begin
        data_o  = frs_i;
        bytes_o = BYTES_W'(DBL_W / 8);
      end
    endcase
  end
endmodule

// File: rtl/fst_store_unit.sv
module fst_store_unit
  import fst_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [1:0]        prec_i,
  input  logic              idx_form_i,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  ra_sel_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic [63:0]       frs_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              req_vld_o,
  output logic [XLEN-1:0]   req_addr_o,
  output logic [3:0]        req_bytes_o,
  output logic [63:0]       req_data_o,
  output logic              wb_vld_o,
  output logic [IDX_W-1:0]  wb_sel_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              bad_form_o
);
  localparam int BYTES_W = 4;

  logic             is_word;
  logic             eff_idx;
  logic             eff_upd;
  logic             ra_zero;
  logic [XLEN-1:0]  ea;
  logic [63:0]      st_data;
  logic [BYTES_W-1:0] st_bytes;

  always_comb begin
    is_word = (prec_e'(prec_i) == PREC_WORD);
    eff_idx = idx_form_i | is_word;
    eff_upd = upd_i & ~is_word;
    ra_zero = (ra_sel_i == '0);
  end

  fst_ea_gen #(
    .XLEN   (XLEN),
    .DISP_W (DISP_W),
    .IDX_W  (IDX_W)
  ) u_ea_gen (
    .idx_form_i (eff_idx),
    .upd_i      (eff_upd),
    .ra_sel_i   (ra_sel_i),
    .ra_val_i   (ra_val_i),
    .rb_val_i   (rb_val_i),
    .disp_i     (disp_i),
    .ea_o       (ea)
  );

  fst_data_fmt #(
    .BYTES_W (BYTES_W)
  ) u_data_fmt (
    .prec_i  (prec_i),
    .frs_i   (frs_i),
    .data_o  (st_data),
    .bytes_o (st_bytes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_vld_o  <= 1'b0;
      wb_vld_o   <= 1'b0;
      bad_form_o <= 1'b0;
    end else begin
      req_vld_o  <= vld_i;
      wb_vld_o   <= vld_i & eff_upd & ~ra_zero;
      bad_form_o <= vld_i & eff_upd & ra_zero;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_addr_o  <= '0;
      req_bytes_o <= '0;
      req_data_o  <= '0;
      wb_sel_o    <= '0;
      wb_data_o   <= '0;
    end else if (vld_i) begin
      req_addr_o  <= ea;
      req_bytes_o <= st_bytes;
      req_data_o  <= st_data;
      wb_sel_o    <= ra_sel_i;
      wb_data_o   <= ea;
    end
  end
endmodule

// File: rtl/fst_store_unit_chk.sv
module fst_store_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        vld_i,
  input logic [1:0]  prec_i,
  input logic [63:0] frs_i,
  input logic        req_vld_o,
  input logic [63:0] req_addr_o,
  input logic [3:0]  req_bytes_o,
  input logic [63:0] req_data_o,
  input logic        wb_vld_o,
  input logic [63:0] wb_data_o,
  input logic        bad_form_o
);
  p_issue_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> req_vld_o);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> (!req_vld_o && !wb_vld_o && !bad_form_o));

  p_wb_ea_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_vld_o |-> (req_vld_o && wb_data_o == req_addr_o));

  p_bad_nowb_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_form_o |-> (req_vld_o && !wb_vld_o));

  p_dbl_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && prec_i == 2'd1) |=> (req_bytes_o == 4'd8 && req_data_o == $past(frs_i)));

  p_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && prec_i == 2'd2) |=>
      (req_bytes_o == 4'd4 && !wb_vld_o && !bad_form_o &&
       req_data_o == {32'h0, $past(frs_i[31:0])}));

  p_sgl_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && prec_i == 2'd0) |=> (req_bytes_o == 4'd4 && req_data_o[63:32] == 32'h0));
endmodule

bind fst_store_unit fst_store_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vld_i       (vld_i),
  .prec_i      (prec_i),
  .frs_i       (frs_i),
  .req_vld_o   (req_vld_o),
  .req_addr_o  (req_addr_o),
  .req_bytes_o (req_bytes_o),
  .req_data_o  (req_data_o),
  .wb_vld_o    (wb_vld_o),
  .wb_data_o   (wb_data_o),
  .bad_form_o  (bad_form_o)
);

// File: tb/fst_store_unit_tb.sv
`timescale 1ns/1ps
module fst_store_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic [1:0]  prec_i = '0;
  logic        idx_form_i = 1'b0;
  logic        upd_i = 1'b0;
  logic [4:0]  ra_sel_i = '0;
  logic [63:0] ra_val_i = '0;
  logic [63:0] rb_val_i = '0;
  logic [63:0] frs_i = '0;
  logic [15:0] disp_i = '0;
  logic        req_vld_o;
  logic [63:0] req_addr_o;
  logic [3:0]  req_bytes_o;
  logic [63:0] req_data_o;
  logic        wb_vld_o;
  logic [4:0]  wb_sel_o;
  logic [63:0] wb_data_o;
  logic        bad_form_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  fst_store_unit dut_i (
    .clk_i, .rst_ni, .vld_i, .prec_i, .idx_form_i, .upd_i, .ra_sel_i,
    .ra_val_i, .rb_val_i, .frs_i, .disp_i, .req_vld_o, .req_addr_o,
    .req_bytes_o, .req_data_o, .wb_vld_o, .wb_sel_o, .wb_data_o, .bad_form_o
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one op on a falling edge; return at the next falling edge with results visible
  task automatic issue(input logic [1:0] p, input logic ix, input logic up,
                       input logic [4:0] rs, input logic [63:0] ra,
                       input logic [63:0] rb, input logic [63:0] fs,
                       input logic [15:0] d);
    prec_i = p; idx_form_i = ix; upd_i = up; ra_sel_i = rs;
    ra_val_i = ra; rb_val_i = rb; frs_i = fs; disp_i = d; vld_i = 1'b1;
    @(negedge clk_i);
    vld_i = 1'b0;
  endtask

  task automatic sgl_case(input string req, input logic [63:0] fs,
                          input logic [31:0] exp);
    issue(2'd0, 1'b1, 1'b0, 5'd2, 64'h0, 64'h80, fs, 16'h0);
    chk(req, "single data", req_data_o, {32'h0, exp});
    chk(req, "single bytes", 64'(req_bytes_o), 64'd4);
  endtask

  task automatic t_reset;
    chk("R13", "req_vld", 64'(req_vld_o), 0);
    chk("R13", "addr", req_addr_o, 0);
    chk("R13", "data", req_data_o, 0);
    chk("R13", "bytes", 64'(req_bytes_o), 0);
    chk("R13", "wb_vld", 64'(wb_vld_o), 0);
    chk("R13", "wb_data", wb_data_o, 0);
    chk("R13", "bad_form", 64'(bad_form_o), 0);
  endtask

  task automatic t_dform;
    issue(2'd1, 1'b0, 1'b0, 5'd3, 64'h1000, 64'h5555, 64'h0123456789abcdef, 16'hfff0);
    chk("R1", "neg disp addr", req_addr_o, 64'h0ff0);
    chk("R6", "dbl data", req_data_o, 64'h0123456789abcdef);
    chk("R6", "dbl bytes", 64'(req_bytes_o), 64'd8);
    chk("R5", "no wb non-update", 64'(wb_vld_o), 0);
    issue(2'd3, 1'b0, 1'b0, 5'd3, 64'h1000, 64'h5555, 64'hfedcba9876543210, 16'h7ff0);
    chk("R1", "pos disp addr", req_addr_o, 64'h8ff0);
    chk("R6", "rsv as dbl data", req_data_o, 64'hfedcba9876543210);
    chk("R6", "rsv as dbl bytes", 64'(req_bytes_o), 64'd8);
  endtask

  task automatic t_xform;
    issue(2'd1, 1'b1, 1'b0, 5'd4, 64'h2000, 64'hffff_ffff_ffff_fff0, 64'h1, 16'h0040);
    chk("R2", "indexed addr", req_addr_o, 64'h1ff0);
    chk("R5", "no wb indexed", 64'(wb_vld_o), 0);
  endtask

  task automatic t_ra0;
    issue(2'd1, 1'b0, 1'b0, 5'd0, 64'hdead0000, 64'h0, 64'h0, 16'hfff8);
    chk("R3", "zero base disp", req_addr_o, 64'hffff_ffff_ffff_fff8);
    issue(2'd0, 1'b1, 1'b0, 5'd0, 64'hdead0000, 64'h340, 64'h0, 16'h0);
    chk("R3", "zero base idx", req_addr_o, 64'h340);
    chk("R11", "no bad non-update", 64'(bad_form_o), 0);
  endtask

  task automatic t_update;
    issue(2'd0, 1'b0, 1'b1, 5'd5, 64'h4000, 64'h0, 64'h0, 16'hfffc);
    chk("R4", "upd disp addr", req_addr_o, 64'h3ffc);
    chk("R5", "wb_vld", 64'(wb_vld_o), 1);
    chk("R5", "wb_sel", 64'(wb_sel_o), 5);
    chk("R5", "wb_data", wb_data_o, 64'h3ffc);
    issue(2'd1, 1'b1, 1'b1, 5'd31, 64'h100, 64'h20, 64'h0, 16'h0);
    chk("R5", "upd idx wb_data", wb_data_o, 64'h120);
    chk("R5", "upd idx wb_sel", 64'(wb_sel_o), 31);
  endtask

  task automatic t_upd_ra0;
    issue(2'd1, 1'b0, 1'b1, 5'd0, 64'h500, 64'h0, 64'h0, 16'h0004);
    chk("R4", "upd ra0 base", req_addr_o, 64'h504);
    chk("R11", "bad_form", 64'(bad_form_o), 1);
    chk("R11", "wb suppressed", 64'(wb_vld_o), 0);
    chk("R11", "store issued", 64'(req_vld_o), 1);
  endtask

  task automatic t_single;
    sgl_case("R7", 64'h3ff0000000000000, 32'h3f800000);
    sgl_case("R7", 64'hc004000000000000, 32'hc0200000);
    sgl_case("R7", 64'h7ff0000000000000, 32'h7f800000);
    sgl_case("R7", 64'h3810000000000000, 32'h00800000);
    chk("R7", "upper zero", {32'h0, req_data_o[63:32]}, 0);
  endtask

  task automatic t_denorm;
    sgl_case("R8", 64'h37d0000000000000, 32'h00080000);
    sgl_case("R8", 64'hb7d0000000000000, 32'h80080000);
    sgl_case("R8", 64'h3800000000000000, 32'h00400000);
    sgl_case("R8", 64'h36a0000000000000, 32'h00000001);
    sgl_case("R8", 64'h37d8000000000000, 32'h000c0000);
  endtask

  task automatic t_trunc;
    sgl_case("R9", 64'h3690000000000000, 32'h34800000);
    sgl_case("R9", 64'h0000000000000000, 32'h00000000);
    sgl_case("R9", 64'h8000000000000000, 32'h80000000);
    sgl_case("R9", 64'h3ff000001fffffff, 32'h3f800000);
  endtask

  task automatic t_word;
    issue(2'd2, 1'b0, 1'b1, 5'd0, 64'h77, 64'h40, 64'h1122334455667788, 16'h0100);
    chk("R10", "word addr", req_addr_o, 64'h40);
    chk("R10", "word data", req_data_o, 64'h55667788);
    chk("R10", "word bytes", 64'(req_bytes_o), 64'd4);
    chk("R10", "word no wb", 64'(wb_vld_o), 0);
    chk("R10", "word no bad", 64'(bad_form_o), 0);
    issue(2'd2, 1'b0, 1'b1, 5'd6, 64'h1000, 64'h8, 64'hffffffff00000000, 16'h0100);
    chk("R10", "word ra base", req_addr_o, 64'h1008);
    chk("R10", "word no wb ra6", 64'(wb_vld_o), 0);
  endtask

  task automatic t_timing;
    issue(2'd1, 1'b0, 1'b1, 5'd7, 64'h10, 64'h0, 64'h0, 16'h0);
    chk("R12", "valid after issue", 64'(req_vld_o), 1);
    @(negedge clk_i);
    chk("R12", "idle req_vld", 64'(req_vld_o), 0);
    chk("R12", "idle wb_vld", 64'(wb_vld_o), 0);
    // back-to-back ops
    prec_i = 2'd1; idx_form_i = 1'b0; upd_i = 1'b0; ra_sel_i = 5'd1;
    ra_val_i = 64'h100; disp_i = 16'h1; vld_i = 1'b1;
    @(negedge clk_i);
    chk("R12", "b2b first addr", req_addr_o, 64'h101);
    disp_i = 16'h2;
    @(negedge clk_i);
    vld_i = 1'b0;
    chk("R12", "b2b second addr", req_addr_o, 64'h102);
    chk("R12", "b2b second vld", 64'(req_vld_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_dform();
    t_xform();
    t_ra0();
    t_update();
    t_upd_ra0();
    t_single();
    t_denorm();
    t_trunc();
    t_word();
    t_timing();
    @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule